// File: doc/BRIEF.md
# Programmable Dual-Modulus Prescaler

This block divides its input clock by either P or P+1, picking between the two with a modulus-control input. A 2-bit ratio setting chooses P from four values (8, 16, 32 or 64). The divide-by-P+1 cycle exists so that a downstream swallow counter can build any integer feedback ratio. It does this by asking for the longer modulus during some of its periods and the shorter one during the rest.

Every ratio is built on one synchronous 4/5 core. A chain of binary extension stages counts core passes. The core runs its five-state pass only in the last pass of a period, and only when the longer modulus was requested. The output is a single-cycle pulse, once per division period, which downstream counters count directly.

The modulus control and the ratio setting are both captured at period boundaries and during reset. A change on either pin therefore never shortens or stretches the period already running. The pins are plain control and status signals. No data stream passes through the block, so it has no valid/ready handshake and no back-pressure.

Top module: `dual_mod_prescaler`

## Requirements
- R1: With the modulus control low, the pulse period is 8, 16, 32 or 64 clock cycles for a ratio setting of 00, 01, 10 or 11 respectively.
- R2: With the modulus control high, the pulse period is one cycle longer than R1 gives for the same setting: 9, 17, 33 or 65.
- R3: The output pulse is high for exactly one clock cycle in each period and is never high in two consecutive cycles.
- R4: The modulus control is captured only at the rising edge where the pulse is high, or at an edge where reset is high. A change at any other time does not alter the length of the period in progress, and it applies to the following period.
- R5: The ratio setting is captured under the same rule as R4. A mid-period change leaves the current period at its old length and governs the next one.
- R6: Reset is synchronous and active high. From the first edge with reset high, the pulse is low while reset stays high. The last edge with reset high starts a period, so the first pulse is seen N-1 edges after reset falls, where N is the period length selected by the inputs during reset.
- R7: The modulus may differ in every period. Toggling the control at each pulse yields periods that alternate between P and P+1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Input clock to be divided |
| rst_i | input | 1 | Synchronous reset, active high |
| ratio_sel_i | input | 2 | Ratio setting: 00=8/9, 01=16/17, 10=32/33, 11=64/65 |
| mod_hi_i | input | 1 | Modulus control: 0 selects P, 1 selects P+1 |
| div_pulse_o | output | 1 | One-cycle pulse marking the end of each division period |

## Verification
The checker keeps its own cycle count from each boundary and forms the expected length from the setting and control it sees at that same edge. It therefore assumes that both inputs are settled before each rising edge, and that reset lasts at least one edge. The bench changes inputs only at falling edges, and it holds reset for several cycles. Every 2-bit setting is a legal ratio, so the stimulus covers all four with both modulus levels. It also moves the control and the setting in the middle of periods to confirm that they are captured only at boundaries.

// File: rtl/dmp_pkg.sv
package dmp_pkg;

  // Upper bound on extension stages the helper functions handle.
  localparam int unsigned MAX_EXT = 8;

  // Phases of the shared divide-by-4/5 core.
  typedef enum logic [2:0] {
    PH0 = 3'd0,
    PH1 = 3'd1,
    PH2 = 3'd2,
    PH3 = 3'd3,
    PH4 = 3'd4
  } core_ph_e;

  // Mask of the extension stages that a ratio setting enables:
  // setting s uses s+1 stages, giving P = 4 * 2^(s+1).
  function automatic logic [MAX_EXT-1:0] stage_mask(input int unsigned sel);
    logic [MAX_EXT-1:0] m;
    m = '0;
    for (int unsigned i = 0; i < MAX_EXT; i++) begin
      if (i <= sel) m[i] = 1'b1;
    end
    return m;
  endfunction

endpackage

// File: rtl/dmp_core45.sv
module dmp_core45
  import dmp_pkg::*;
(
  input  logic     clk_i,
  input  logic     rst_i,
  input  logic     swallow_i,  // take the five-state pass this time
  output logic     pass_end_o, // last input cycle of the current pass
  output core_ph_e phase_o
);

  core_ph_e ph_q;
  core_ph_e ph_d;

  always_comb begin
    pass_end_o = 1'b0;
    ph_d       = PH0;
    unique case (ph_q)
      PH0: ph_d = PH1;
      PH1: ph_d = PH2;
      PH2: ph_d = PH3;
      PH3: begin
        if (swallow_i) begin
          ph_d = PH4;
        end else begin
          ph_d       = PH0;
          pass_end_o = 1'b1;
        end
      end
      PH4: begin
        ph_d       = PH0;
        pass_end_o = 1'b1;
      end
      default: ph_d = PH0;
    endcase
  end

  always_ff @(posedge clk_i) begin
    if (rst_i) ph_q <= PH0;
    else       ph_q <= ph_d;
  end

  assign phase_o = ph_q;

endmodule

// File: rtl/dmp_ext_chain.sv
module dmp_ext_chain #(
  parameter int unsigned EXT_STAGES = 4
) (
  input  logic                  clk_i,
  input  logic                  rst_i,
  input  logic                  adv_i,   // one core pass completed
  input  logic                  clr_i,   // period boundary
  input  logic [EXT_STAGES-1:0] mask_i,  // stages in use this period
  output logic                  at_top_o // final core pass of the period
);

  logic [EXT_STAGES-1:0] bit_q;
  logic [EXT_STAGES:0]   carry;

  assign carry[0] = adv_i;

  for (genvar i = 0; i < EXT_STAGES; i++) begin : g_stage
    assign carry[i+1] = carry[i] & bit_q[i];

    always_ff @(posedge clk_i) begin
      if (rst_i || clr_i)               bit_q[i] <= 1'b0;
      else if (carry[i] && mask_i[i])   bit_q[i] <= ~bit_q[i];
    end
  end

  assign at_top_o = (bit_q == mask_i);

endmodule

// File: rtl/dmp_period_ctl.sv
module dmp_period_ctl
  import dmp_pkg::*;
#(
  parameter int unsigned EXT_STAGES = 4,
  localparam int unsigned SEL_W = $clog2(EXT_STAGES)
) (
  input  logic                  clk_i,
  input  logic                  rst_i,
  input  logic                  bound_i,
  input  logic [SEL_W-1:0]      sel_i,
  input  logic                  mod_i,
  output logic [EXT_STAGES-1:0] mask_o,
  output logic                  long_o
);

  logic [SEL_W-1:0] sel_q;
  logic             mod_q;
  logic [MAX_EXT-1:0] full_mask;

  // Setting and modulus are captured only at a boundary or in reset.
  always_ff @(posedge clk_i) begin
    if (rst_i || bound_i) begin
      sel_q <= sel_i;
      mod_q <= mod_i;
    end
  end

  assign full_mask = stage_mask(int'(sel_q));
  assign mask_o    = full_mask[EXT_STAGES-1:0];
  assign long_o    = mod_q;

endmodule

// File: rtl/dual_mod_prescaler.sv
module dual_mod_prescaler
  import dmp_pkg::*;
#(
  parameter int unsigned EXT_STAGES = 4,
  localparam int unsigned SEL_W = $clog2(EXT_STAGES)
) (
  input  logic             clk_i,
  input  logic             rst_i,
  input  logic [SEL_W-1:0] ratio_sel_i,
  input  logic             mod_hi_i,
  output logic             div_pulse_o
);

  logic                  pass_end;
  logic                  at_top;
  logic                  long_sel;
  logic                  bound;
  logic [EXT_STAGES-1:0] mask;
  core_ph_e              core_ph;
  logic [2:0]            core_phase;

  dmp_period_ctl #(.EXT_STAGES(EXT_STAGES)) u_ctl (
    .clk_i  (clk_i),
    .rst_i  (rst_i),
    .bound_i(bound),
    .sel_i  (ratio_sel_i),
    .mod_i  (mod_hi_i),
    .mask_o (mask),
    .long_o (long_sel)
  );

  dmp_core45 u_core (
    .clk_i     (clk_i),
    .rst_i     (rst_i),
    .swallow_i (at_top & long_sel),
    .pass_end_o(pass_end),
    .phase_o   (core_ph)
  );

  dmp_ext_chain #(.EXT_STAGES(EXT_STAGES)) u_ext (
    .clk_i   (clk_i),
    .rst_i   (rst_i),
    .adv_i   (pass_end),
    .clr_i   (bound),
    .mask_i  (mask),
    .at_top_o(at_top)
  );

  assign bound       = pass_end & at_top;
  assign div_pulse_o = bound;
  assign core_phase  = core_ph;

endmodule

// File: rtl/dual_mod_prescaler_chk.sv
module dual_mod_prescaler_chk #(
  parameter int unsigned EXT_STAGES = 4,
  localparam int unsigned SEL_W = $clog2(EXT_STAGES)
) (
  input logic             clk_i,
  input logic             rst_i,
  input logic [SEL_W-1:0] ratio_sel_i,
  input logic             mod_hi_i,
  input logic             div_pulse_o,
  input logic [2:0]       core_phase
);

  logic [9:0] cyc_q;
  logic [9:0] len_q;
  logic       rst_q;

  // Independent period model built from the ports.
  always_ff @(posedge clk_i) begin
    rst_q <= rst_i;
    if (rst_i || div_pulse_o) begin
      cyc_q <= '0;
      len_q <= 10'((4 << (int'(ratio_sel_i) + 1)) + int'(mod_hi_i));
    end else begin
      cyc_q <= cyc_q + 10'd1;
    end
  end

  // R1 and R2: a pulse only at the end of the selected length.
  assert_pulse_on_time_R1: assert property (@(posedge clk_i) disable iff (rst_i)
    div_pulse_o |-> (cyc_q == len_q - 10'd1));

  // R4 and R5: the length captured at the boundary is never cut short.
  assert_period_complete_R4: assert property (@(posedge clk_i) disable iff (rst_i)
    (cyc_q == len_q - 10'd1) |-> div_pulse_o);

  assert_single_pulse_R3: assert property (@(posedge clk_i) disable iff (rst_i)
    div_pulse_o |=> !div_pulse_o);

  // R2: the fifth core phase occurs only in the final pass of a period.
  assert_swallow_last_R2: assert property (@(posedge clk_i) disable iff (rst_i)
    (core_phase == 3'd4) |-> div_pulse_o);

  assert_quiet_after_reset_R6: assert property (@(posedge clk_i)
    rst_q |-> !div_pulse_o);

endmodule

bind dual_mod_prescaler dual_mod_prescaler_chk #(.EXT_STAGES(EXT_STAGES)) u_chk (
  .clk_i      (clk_i),
  .rst_i      (rst_i),
  .ratio_sel_i(ratio_sel_i),
  .mod_hi_i   (mod_hi_i),
  .div_pulse_o(div_pulse_o),
  .core_phase (core_phase)
);

// File: tb/dual_mod_prescaler_tb.sv
module dual_mod_prescaler_tb;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic [1:0] sel = 2'b00;
  logic       mod = 1'b0;
  logic       pulse;

  int n_chk = 0;
  int n_bad = 0;

  always #4 clk = ~clk;

  dual_mod_prescaler u_dut (
    .clk_i      (clk),
    .rst_i      (rst),
    .ratio_sel_i(sel),
    .mod_hi_i   (mod),
    .div_pulse_o(pulse)
  );

  function automatic int exp_len(input logic [1:0] s, input logic m);
    return (8 << s) + int'(m);
  endfunction

  task automatic check(input bit ok, input string req, input int act, input int expv);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, expv);
    end
  endtask

  // Count falling edges until the pulse is seen.
  task automatic wait_pulse(output int g);
    g = 0;
    do begin
      @(negedge clk);
      g++;
    end while (!pulse && g < 300);
  endtask

  task automatic do_reset(input logic [1:0] s, input logic m);
    @(negedge clk);
    rst = 1'b1;
    sel = s;
    mod = m;
    repeat (3) begin
      @(negedge clk);
      check(pulse == 1'b0, "R6 pulse low in reset", int'(pulse), 0);
    end
    rst = 1'b0;
  endtask

  // R1/R2/R3/R6: fixed setting and modulus.
  task automatic t_fixed(input logic [1:0] s, input logic m);
    int g;
    int n;
    n = exp_len(s, m);
    do_reset(s, m);
    wait_pulse(g);
    check(g == n - 1, "R6 first pulse after reset", g, n - 1);
    for (int p = 0; p < 3; p++) begin
      wait_pulse(g);
      if (m) check(g == n, "R2 period with control high", g, n);
      else   check(g == n, "R1 period with control low", g, n);
    end
    @(negedge clk);
    check(pulse == 1'b0, "R3 pulse lasts one cycle", int'(pulse), 0);
  endtask

  // R7: modulus toggled at every pulse.
  task automatic t_alternate();
    int g;
    logic cur;
    do_reset(2'b01, 1'b0);
    wait_pulse(g);
    cur = 1'b1;
    mod = cur;
    for (int p = 0; p < 6; p++) begin
      wait_pulse(g);
      check(g == exp_len(2'b01, cur), "R7 alternating period", g, exp_len(2'b01, cur));
      cur = ~cur;
      mod = cur;
    end
  endtask

  // R4: control changed mid-period.
  task automatic t_mid_mod();
    int g;
    do_reset(2'b00, 1'b0);
    wait_pulse(g);
    g = 0;
    repeat (3) begin @(negedge clk); g++; end
    mod = 1'b1;
    while (!pulse && g < 300) begin @(negedge clk); g++; end
    check(g == 8, "R4 current period unchanged", g, 8);
    wait_pulse(g);
    check(g == 9, "R4 change applies next period", g, 9);
    g = 0;
    repeat (4) begin @(negedge clk); g++; end
    mod = 1'b0;
    while (!pulse && g < 300) begin @(negedge clk); g++; end
    check(g == 9, "R4 long period not cut short", g, 9);
  endtask

  // R5: ratio setting changed mid-period.
  task automatic t_mid_cfg();
    int g;
    do_reset(2'b00, 1'b0);
    wait_pulse(g);
    g = 0;
    repeat (2) begin @(negedge clk); g++; end
    sel = 2'b11;
    while (!pulse && g < 300) begin @(negedge clk); g++; end
    check(g == 8, "R5 current period keeps old ratio", g, 8);
    wait_pulse(g);
    check(g == 64, "R5 new ratio next period", g, 64);
    g = 0;
    repeat (10) begin @(negedge clk); g++; end
    sel = 2'b10;
    mod = 1'b1;
    while (!pulse && g < 300) begin @(negedge clk); g++; end
    check(g == 64, "R5 long ratio not cut short", g, 64);
    wait_pulse(g);
    check(g == 33, "R5 setting and control applied together", g, 33);
  endtask

  initial begin
    #(8 * 150000);
    n_chk++;
    n_bad++;
    $display("FAIL watchdog expired actual=1 expected=0");
    $display("test done: total=%0d bad=%0d", n_chk, n_bad);
    $finish;
  end

  initial begin
    for (int s = 0; s < 4; s++) begin
      t_fixed(2'(s), 1'b0);
      t_fixed(2'(s), 1'b1);
    end
    t_alternate();
    t_mid_mod();
    t_mid_cfg();
    $display("test done: total=%0d bad=%0d", n_chk, n_bad);
    $finish;
  end

endmodule